// File: doc/BRIEF.md
# Byte-Lane Pipelined Synchronous SRAM

This block is a single-port synchronous static RAM model that can be synthesized. It has one shared bidirectional data bus. The bus is split into two 9-bit byte lanes, and each lane has its own active-low enable. Address, select, write strobe and lane enables are captured on the rising clock edge. On a write, the data on the bus is captured on that same edge and committed internally with no added cycles. On a read, the array is looked up during the following cycle, and the result is held in an output register whose drivers turn on after the next edge.

An active-low output enable gates the bus drivers combinationally, on top of the clocked output register. Depth is a parameter, with a default of 1024 words, and the address width is derived from it. Memory contents are undefined until written.

The bus runs at fixed timing and has no handshake. A command is accepted on every edge, nothing stalls, and no back-pressure exists. A system that drives the bus must leave it released during the cycle in which the RAM drives read data.

Top module: `sram_lanes`

## Requirements
- R1: After reset and with no access issued, the data bus is high impedance.
- R2: A read (`cs_n`=0, `we_n`=1) sampled at edge n leaves the bus high impedance until edge n+1. From edge n+1 the bus carries the read word.
- R3: A write (`cs_n`=0, `we_n`=0, both `lane_n` bits low) stores the full 18-bit word on the bus at the sampling edge, and a later read of that address returns it.
- R4: A write stores only the lanes whose enable is low. `lane_n[0]` selects bits 8:0 and `lane_n[1]` selects bits 17:9. The other lane of the word keeps its old value.
- R5: During a read, a lane whose enable was high is high impedance in the data cycle, even while the other lane drives. With both enables high, the whole bus stays high impedance.
- R6: `oe_n` high holds the bus high impedance even during a read data cycle. Lowering `oe_n` drives the registered read data without waiting for a clock edge.
- R7: A cycle with `cs_n` high stores nothing, and the bus is high impedance in the cycle that follows.
- R8: The RAM does not drive the bus in the cycle after a write.
- R9: A read issued on the edge right after a write to the same address returns the newly written data.
- R10: Reads on consecutive edges return their words on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| addr | input | $clog2(DEPTH) | Word address |
| cs_n | input | 1 | Active-low select; high means deselect |
| we_n | input | 1 | Active-low write strobe; high means read |
| lane_n | input | 2 | Active-low lane enables; bit 0 lower lane, bit 1 upper lane |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dq | inout | 18 | Shared data bus |

## Verification
The bench first goes after the pipeline timing. It checks the bus one cycle after a read is issued, where it must still be released, and then a cycle later. A design that drove data one cycle early or one cycle late fails one of those two samples.

Lane isolation is probed separately for writes and for reads. A design that merged lanes would overwrite the untouched half of the word. A design that ignored lane masks on a read would drive a lane that should be floating.

A write immediately followed by a read of the same address exposes a missing write-to-read forwarding path, which would return stale data. The bench also toggles `oe_n` inside a data cycle and samples without a clock edge. This catches an output enable that is wrongly registered.

// File: rtl/sram_lanes_pkg.sv
`timescale 1ns/1ps
package sram_lanes_pkg;
  localparam int LANE_W_DEF = 9;
  localparam int LANES_DEF  = 2;

  // Command decoded at the input register
  typedef struct packed {
    logic act;  // chip selected this cycle
    logic wr;   // write when act, read otherwise
  } op_t;
endpackage

// File: rtl/sram_in_stage.sv
`timescale 1ns/1ps
module sram_in_stage
  import sram_lanes_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = LANES_DEF,
  parameter int DW    = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output op_t              op_q,
  output logic [LANES-1:0] lane_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    din_q
);
  // Control flops are reset so the bus is quiet from reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      lane_q <= '0;
    end else begin
      op_q.act <= ~cs_n;
      op_q.wr  <= ~we_n;
      lane_q   <= ~lane_n;
    end
  end

  // Datapath flops carry no reset
  always_ff @(posedge clk) begin
    addr_q <= addr;
    din_q  <= din;
  end
endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array #(
  parameter int DEPTH = 1024,
  parameter int LW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] rdata
);
  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (32'(addr) < DEPTH)) mem[addr] <= wdata;
  end

  // Combinational read of the registered address; output stage registers it
  assign rdata = mem[addr];
endmodule

// File: rtl/sram_out_stage.sv
`timescale 1ns/1ps
module sram_out_stage
  import sram_lanes_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int LW    = LANE_W_DEF,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_t              op_q,
  input  logic [LANES-1:0] lane_q,
  input  logic [DW-1:0]    rdata,
  output logic [DW-1:0]    dout_q,
  output logic [LANES-1:0] drv_q
);
  logic rd_now;
  assign rd_now = op_q.act & ~op_q.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= '0;
    else        drv_q <= rd_now ? lane_q : '0;
  end

  always_ff @(posedge clk) begin
    if (rd_now) dout_q <= rdata;
  end

  assert_wr_cycle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q.act && op_q.wr) |=> (drv_q == '0));

  assert_desel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_q.act |=> (drv_q == '0));

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      assert_lane_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && lane_q[l]) |=> drv_q[l]);
      assert_lane_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && !lane_q[l]) |=> !drv_q[l]);
    end
  endgenerate
endmodule

// File: rtl/sram_lanes.sv
`timescale 1ns/1ps
module sram_lanes
  import sram_lanes_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int LW    = LANE_W_DEF,
  parameter int LANES = LANES_DEF,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LW * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             oe_n,
  inout  wire  [DW-1:0]    dq
);
  op_t              op_q;
  logic [LANES-1:0] lane_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    din_q;
  logic [DW-1:0]    rdata;
  logic [DW-1:0]    dout_q;
  logic [LANES-1:0] drv_q;

  sram_in_stage #(.AW(AW), .LANES(LANES), .DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .lane_n(lane_n),
    .addr(addr), .din(dq), .op_q(op_q), .lane_q(lane_q),
    .addr_q(addr_q), .din_q(din_q)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      sram_lane_array #(.DEPTH(DEPTH), .LW(LW)) u_arr (
        .clk(clk),
        .wr_en(op_q.act & op_q.wr & lane_q[l]),
        .addr(addr_q),
        .wdata(din_q[l*LW +: LW]),
        .rdata(rdata[l*LW +: LW])
      );
      assign dq[l*LW +: LW] = (drv_q[l] && !oe_n) ? dout_q[l*LW +: LW] : {LW{1'bz}};
    end
  endgenerate

  sram_out_stage #(.LANES(LANES), .LW(LW)) u_out (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .lane_q(lane_q),
    .rdata(rdata), .dout_q(dout_q), .drv_q(drv_q)
  );
endmodule

// File: tb/tb_sram_lanes.sv
`timescale 1ns/1ps
module tb_sram_lanes;
  localparam int AW = 10;
  localparam logic [8:0] ZL = 9'bz;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [1:0] lane_n = 2'b11;
  logic [17:0] tb_d = '0;
  logic tb_en = 1'b0;
  wire  [17:0] dq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign dq = tb_en ? tb_d : 18'bz;

  sram_lanes dut (.clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n),
    .we_n(we_n), .lane_n(lane_n), .oe_n(oe_n), .dq(dq));

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic idle();
    cs_n = 1'b1; we_n = 1'b1; lane_n = 2'b11; tb_en = 1'b0;
  endtask

  // Issue one write; returns one cycle later with idle applied
  task automatic wr(logic [AW-1:0] a, logic [1:0] ln, logic [17:0] d);
    addr = a; cs_n = 1'b0; we_n = 1'b0; lane_n = ln; tb_d = d; tb_en = 1'b1;
    step(); idle();
  endtask

  task automatic rd_issue(logic [AW-1:0] a, logic [1:0] ln);
    addr = a; cs_n = 1'b0; we_n = 1'b1; lane_n = ln; tb_en = 1'b0;
  endtask

  // Read with latency check; leaves one quiet cycle afterwards
  task automatic rd_check(string req, logic [AW-1:0] a, logic [1:0] ln, logic [17:0] exp);
    rd_issue(a, ln); step();
    chk({req, " R2 early"}, dq, 18'bz);
    idle(); step();
    chk(req, dq, exp);
    step();
  endtask

  task automatic t_reset();
    step(); step();
    chk("R1 reset bus", dq, 18'bz);
  endtask

  task automatic t_write_read();
    wr(10'd5, 2'b00, 18'h2A5A5);
    step();
    chk("R8 after write", dq, 18'bz);
    rd_check("R3 full word", 10'd5, 2'b00, 18'h2A5A5);
    wr(10'd6, 2'b00, 18'h1C3F0); step();
    rd_check("R3 second word", 10'd6, 2'b00, 18'h1C3F0);
  endtask

  task automatic t_lane_write();
    wr(10'd7, 2'b00, {9'h1AA, 9'h055}); step();
    wr(10'd7, 2'b10, {9'h0FF, 9'h123}); step();
    rd_check("R4 lower only", 10'd7, 2'b00, {9'h1AA, 9'h123});
    wr(10'd7, 2'b01, {9'h0C3, 9'h1FF}); step();
    rd_check("R4 upper only", 10'd7, 2'b00, {9'h0C3, 9'h123});
  endtask

  task automatic t_lane_read();
    rd_check("R5 lower lane read", 10'd7, 2'b10, {ZL, 9'h123});
    rd_check("R5 upper lane read", 10'd7, 2'b01, {9'h0C3, ZL});
    rd_check("R5 no lane read", 10'd7, 2'b11, 18'bz);
  endtask

  task automatic t_oe();
    rd_issue(10'd5, 2'b00); step();
    idle(); oe_n = 1'b1; step();
    chk("R6 oe high", dq, 18'bz);
    #0.5 oe_n = 1'b0; #0.5;
    chk("R6 oe async release", dq, 18'h2A5A5);
    step();
  endtask

  task automatic t_desel();
    addr = 10'd5; cs_n = 1'b1; we_n = 1'b0; lane_n = 2'b00;
    tb_d = 18'h3FFFF; tb_en = 1'b1;
    step(); idle(); step();
    chk("R7 deselect quiet", dq, 18'bz);
    rd_check("R7 no store", 10'd5, 2'b00, 18'h2A5A5);
  endtask

  task automatic t_b2b();
    wr(10'd9, 2'b00, 18'h0BEEF);
    rd_issue(10'd9, 2'b00); step();
    idle();
    chk("R8 write then read quiet", dq, 18'bz);
    step();
    chk("R9 read after write", dq, 18'h0BEEF);
    step();
  endtask

  task automatic t_stream();
    rd_issue(10'd5, 2'b00); step();
    rd_issue(10'd7, 2'b00); step();
    chk("R10 stream first", dq, 18'h2A5A5);
    rd_issue(10'd9, 2'b00); step();
    chk("R10 stream second", dq, {9'h0C3, 9'h123});
    idle(); step();
    chk("R10 stream third", dq, 18'h0BEEF);
    step();
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_lane_write();
    t_lane_read();
    t_oe();
    t_desel();
    t_b2b();
    t_stream();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule